// File: doc/BRIEF.md
# Funnel Shifter with Source Generator

A purely combinational N-bit shifter that covers six shift kinds with one shared selection network: logical right, arithmetic right, rotate right, logical left, arithmetic left and rotate left. A small front end forms a 2N-1-bit funnel word from the operand. The bits it places next to the operand depend on the operation: zeros, copies of the sign bit, or the operand's own bits for a rotate. It also forms a window offset, which is the shift amount for right operations and its bitwise complement for left operations.

A network of log2(N) stages of 2:1 multiplexers then extracts an N-bit window from the funnel word. Each stage is steered directly by one bit of the offset, so the shift amount is never decoded. The block is meant to sit inside an execution datapath. The shift amount is always below N, so larger shifts and carry-out flags belong to the surrounding logic.

Top module: `funnel_shifter`

## Requirements
- R1: Logical right shift (op 3'b000) by k: res_o[N-1-k:0] = opa_i[N-1:k], and the top k result bits are 0.
- R2: Arithmetic right shift (op 3'b001) by k: as R1, but the top k result bits equal opa_i[N-1].
- R3: Rotate right (op 3'b010) by k: res_o[i] = opa_i[(i+k) mod N] for every i.
- R4: Logical left (op 3'b100) and arithmetic left (op 3'b101) both give res_o[N-1:k] = opa_i[N-1-k:0] with the low k result bits 0, so the two codes give identical results.
- R5: Rotate left (op 3'b110) by k: res_o[i] = opa_i[(i-k) mod N] for every i.
- R6: With a shift amount of 0, res_o equals opa_i for every op code.
- R7: Op encoding: bit 2 selects left (1) or right (0); bits 1:0 select logical (00), arithmetic (01) or rotate (10). The code 11 in bits 1:0 behaves as logical in the chosen direction.
- R8: Both rotates preserve the number of 1 bits in the operand.
- R9: The width N is a parameter that must be a power of two of at least 2; the shift amount port is log2(N) bits wide. Behaviour holds at N = 8 and N = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | N | Operand to shift |
| amt_i | input | log2(N) | Shift amount k, 0 to N-1 |
| op_i | input | 3 | Operation code (see R7) |
| res_o | output | N | Shifted result |

## Verification
The embedded checks evaluate, on every input change, the properties visible from a single vector: pass-through at zero amount, zero fill at the vacated end of logical shifts, the sign bit at the top of arithmetic right shifts, and the preserved population count of rotates. Exact bit placement for every amount, including the wrap-around order of rotates, is only shown by the bench. The bench also shows that left arithmetic equals left logical and that the reserved codes act as logical. It does this by comparing every op code and every amount against a bit-by-bit reference model at two widths.

// File: rtl/funnel_pkg.sv
`timescale 1ns/1ps
package funnel_pkg;
   // op[2]: direction, op[1:0]: fill kind
   typedef enum logic [1:0] {
      FILL_ZERO = 2'b00,
      FILL_SIGN = 2'b01,
      FILL_WRAP = 2'b10,
      FILL_RSVD = 2'b11
   } fill_kind_e;

   localparam logic DIR_RIGHT = 1'b0;
   localparam logic DIR_LEFT  = 1'b1;

   localparam int OP_W = 3;
endpackage

// File: rtl/funnel_src_gen.sv
`timescale 1ns/1ps
module funnel_src_gen
   import funnel_pkg::*;
#(
   parameter int N  = 32,
   parameter int SW = $clog2(N),
   localparam int ZW = 2*N - 1
) (
   input  logic [N-1:0]    opa_i,
   input  logic [SW-1:0]   amt_i,
   input  logic [OP_W-1:0] op_i,
   output logic [ZW-1:0]   fun_o,
   output logic [SW-1:0]   off_o
);
   fill_kind_e   kind;
   logic         dir;
   logic [N-2:0] pad_right;
   logic [N-2:0] pad_left;

   always_comb begin
      kind = fill_kind_e'(op_i[1:0]);
      dir  = op_i[2];
      unique case (kind)
         FILL_WRAP: pad_right = opa_i[N-2:0];
         FILL_SIGN: pad_right = {(N-1){opa_i[N-1]}};
         default:   pad_right = '0;
      endcase
      pad_left = (kind == FILL_WRAP) ? opa_i[N-1:1] : '0;
      if (dir == DIR_LEFT) begin
         fun_o = {opa_i, pad_left};
         off_o = ~amt_i;
      end else begin
         fun_o = {pad_right, opa_i};
         off_o = amt_i;
      end
   end
endmodule

// File: rtl/funnel_mux_stage.sv
`timescale 1ns/1ps
module funnel_mux_stage #(
   parameter int IN_W = 63,
   parameter int STEP = 1,
   localparam int OUT_W = IN_W - STEP
) (
   input  logic [IN_W-1:0]  din_i,
   input  logic             sel_i,
   output logic [OUT_W-1:0] dout_o
);
   if (OUT_W < 1) begin : g_bad
      $error("funnel_mux_stage: STEP must be below IN_W");
   end

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      assign dout_o[b] = sel_i ? din_i[b + STEP] : din_i[b];
   end
endmodule

// File: rtl/funnel_window.sv
`timescale 1ns/1ps
module funnel_window #(
   parameter int N  = 32,
   parameter int SW = $clog2(N),
   localparam int ZW = 2*N - 1
) (
   input  logic [ZW-1:0] fun_i,
   input  logic [SW-1:0] off_i,
   output logic [N-1:0]  win_o
);
   // stage g consumes 2N-2^g bits and emits 2N-2^(g+1) bits
   for (genvar g = 0; g < SW; g++) begin : g_stg
      localparam int IW = 2*N - (1 << g);
      localparam int OW = 2*N - (2 << g);
      logic [OW-1:0] lvl;
      logic [IW-1:0] src;
      if (g == 0) begin : g_first
         assign src = fun_i;
      end else begin : g_next
         assign src = g_stg[g-1].lvl;
      end
      funnel_mux_stage #(.IN_W(IW), .STEP(1 << g)) u_stage (
         .din_i  (src),
         .sel_i  (off_i[g]),
         .dout_o (lvl)
      );
   end

   assign win_o = g_stg[SW-1].lvl;
endmodule

// File: rtl/funnel_shifter.sv
`timescale 1ns/1ps
module funnel_shifter
   import funnel_pkg::*;
#(
   parameter int N = 32,
   localparam int SW = (N < 2) ? 1 : $clog2(N),
   localparam int ZW = 2*N - 1
) (
   input  logic [N-1:0]  opa_i,
   input  logic [SW-1:0] amt_i,
   input  logic [2:0]    op_i,
   output logic [N-1:0]  res_o
);
   // R9: width must be a power of two, at least 2
   if (N < 2 || (1 << SW) != N) begin : g_width_chk
      $error("funnel_shifter: N must be a power of two >= 2");
   end

   logic [ZW-1:0] fun;
   logic [SW-1:0] off;

   funnel_src_gen #(.N(N), .SW(SW)) u_src (
      .opa_i (opa_i),
      .amt_i (amt_i),
      .op_i  (op_i),
      .fun_o (fun),
      .off_o (off)
   );

   funnel_window #(.N(N), .SW(SW)) u_win (
      .fun_i (fun),
      .off_i (off),
      .win_o (res_o)
   );

   logic [N-1:0] high_mask;
   logic         is_rot;
   logic         is_lsr;
   logic         is_asr;
   logic         is_lsl;

   always_comb begin
      high_mask = ~({N{1'b1}} >> amt_i);
      is_rot = (op_i[1:0] == 2'b10);
      is_asr = (op_i == 3'b001);
      is_lsr = (op_i[2] == 1'b0) && (op_i[1:0] == 2'b00 || op_i[1:0] == 2'b11);
      is_lsl = (op_i[2] == 1'b1) && (op_i[1:0] != 2'b10);
      // R6
      pass_through_chk: assert (amt_i != '0 || res_o == opa_i);
      // R8
      rot_popcount_chk: assert (!is_rot || $countones(res_o) == $countones(opa_i));
      // R1
      lsr_zero_chk: assert (!is_lsr || (res_o & high_mask) == '0);
      // R2
      asr_sign_chk: assert (!is_asr || res_o[N-1] == opa_i[N-1]);
      // R4
      lsl_zero_chk: assert (!is_lsl || amt_i == '0 || res_o[0] == 1'b0);
   end
endmodule

// File: tb/funnel_shifter_bench.sv
`timescale 1ns/1ps
module funnel_shifter_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] a32;
   logic [4:0]  k32;
   logic [2:0]  op32;
   logic [31:0] y32;
   logic [7:0]  a8;
   logic [2:0]  k8;
   logic [2:0]  op8;
   logic [7:0]  y8;

   funnel_shifter #(.N(32)) u_funnel_shifter (
      .opa_i(a32), .amt_i(k32), .op_i(op32), .res_o(y32));
   funnel_shifter #(.N(8)) u_funnel_shifter_n8 (
      .opa_i(a8), .amt_i(k8), .op_i(op8), .res_o(y8));

   // reference built from R1-style bit rules, per op code (R7)
   function automatic logic [31:0] ref_fn(int n, logic [31:0] a, int k, logic [2:0] op);
      logic [31:0] r = '0;
      for (int i = 0; i < n; i++) begin
         if (op[2] == 1'b0) begin
            int s = i + k;
            if (s < n) r[i] = a[s];
            else if (op[1:0] == 2'b10) r[i] = a[s - n];   // R3
            else if (op[1:0] == 2'b01) r[i] = a[n - 1];   // R2
            else r[i] = 1'b0;                             // R1
         end else begin
            int s = i - k;
            if (s >= 0) r[i] = a[s];
            else if (op[1:0] == 2'b10) r[i] = a[s + n];   // R5
            else r[i] = 1'b0;                             // R4
         end
      end
      return r;
   endfunction

   function automatic string req_of(logic [2:0] op, int k);
      if (k == 0) return "R6";
      case (op)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b100, 3'b101: return "R4";
         3'b110: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic run32(logic [31:0] a, int k, logic [2:0] op);
      logic [31:0] exp;
      @(negedge clk);
      a32 = a; k32 = k[4:0]; op32 = op;
      #1;
      exp = ref_fn(32, a, k, op);
      n_chk++;
      if (y32 !== exp) begin
         n_fail++;
         $display("FAIL %s N=32 op=%0d k=%0d a=%h actual=%h expected=%h",
                  req_of(op, k), op, k, a, y32, exp);
      end
      if (op[1:0] == 2'b10) begin   // R8
         n_chk++;
         if ($countones(y32) != $countones(a)) begin
            n_fail++;
            $display("FAIL R8 N=32 ones actual=%0d expected=%0d",
                     $countones(y32), $countones(a));
         end
      end
   endtask

   task automatic run8(logic [7:0] a, int k, logic [2:0] op);
      logic [31:0] exp;
      @(negedge clk);
      a8 = a; k8 = k[2:0]; op8 = op;
      #1;
      exp = ref_fn(8, {24'h0, a}, k, op);
      n_chk++;
      if ({24'h0, y8} !== exp) begin
         n_fail++;
         $display("FAIL %s R9 N=8 op=%0d k=%0d a=%h actual=%h expected=%h",
                  req_of(op, k), op, k, a, y8, exp[7:0]);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      a32 = '0; k32 = '0; op32 = '0; a8 = '0; k8 = '0; op8 = '0;
      repeat (2) @(negedge clk);
      // directed corners on N=8
      for (int op = 0; op < 8; op++) begin
         run8(8'hB5, 0, op[2:0]);   // R6
         run8(8'hB5, 1, op[2:0]);
         run8(8'h80, 7, op[2:0]);   // R2 sign fill across whole word
         run8(8'h01, 7, op[2:0]);   // R5/R3 wrap
      end
      // exhaustive op and amount, random operands (R9 at both widths)
      for (int op = 0; op < 8; op++)
         for (int k = 0; k < 8; k++)
            for (int r = 0; r < 30; r++) run8(8'($urandom), k, op[2:0]);
      for (int op = 0; op < 8; op++) begin
         run32(32'h8000_0001, 31, op[2:0]);
         run32(32'hFFFF_FFFF, 16, op[2:0]);
         run32(32'h0000_0000, 5, op[2:0]);
         for (int k = 0; k < 32; k++)
            for (int r = 0; r < 15; r++) run32($urandom, k, op[2:0]);
      end
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule